// File: doc/BRIEF.md
# Illegal-Opcode Exception Trap Unit

This block watches every instruction word that the core executes and recognises one reserved encoding family as an illegal operation. When such a word executes, the block raises a fetch redirect to a fixed handler vector in the same cycle. It also performs the exception state save. The return PC goes into a debug-return PC backup register. The program status word as it stood before the trap goes into a status backup register. In the status word itself, the non-maskable-pending, exception-active and interrupt-disable flags are all set.

The block owns the program status word. The core updates the flags through a plain write port. A trap that executes in the same cycle as such a write takes priority over it.

The illegal instruction has no other architectural effect. Non-matching instructions leave the backup registers and the status word untouched.

Top module: `ito_trap_unit`

## Requirements
- R1: When exec_valid is 1 and instr is illegal, redir_valid is 1 in that same cycle. An illegal word has instr[10:5] = 111111b, instr[26:23] in the range 0111b..1111b, and instr[16] = 0. All other bits are ignored.
- R2: When exec_valid is 0, redir_valid is 0 whatever instr holds.
- R3: While redir_valid is 1, redir_pc is 0x00000060.
- R4: On the clock edge that ends a trap cycle, dbpc takes the value of ret_pc.
- R5: On that same edge, dbpsw takes the value psw held before the edge.
- R6: On that same edge, psw takes its old value with bit 7 (NP), bit 6 (EP) and bit 5 (ID) set. Bits 4..0 (SAT, CY, OV, S, Z) are kept.
- R7: Synchronous reset sets psw to 0x00000020 (only ID set) and sets dbpc and dbpsw to 0.
- R8: In a cycle with no trap, dbpc and dbpsw keep their values. In a cycle with no trap and no write, psw also keeps its value.
- R9: In a cycle with psw_wr = 1 and no trap, psw takes psw_wdata[7:0], and bits 31..8 of psw read zero.
- R10: When a trap and psw_wr coincide, the trap update of R6 wins and psw_wdata is discarded.
- R11: Boundary encodings do not trap: instr[26:23] = 0110b, instr[16] = 1, or any single zero in instr[10:5]. The values 0111b and 1111b in instr[26:23] do trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exec_valid | input | 1 | Instruction on instr executes this cycle |
| instr | input | 32 | Executed instruction word |
| ret_pc | input | 32 | Return PC to save on a trap |
| psw_wr | input | 1 | Core write strobe for the status word |
| psw_wdata | input | 32 | Core write data for the status word |
| redir_valid | output | 1 | Fetch redirect request (trap taken) |
| redir_pc | output | 32 | Redirect target, the handler vector |
| psw | output | 32 | Current program status word |
| dbpc | output | 32 | Saved return PC |
| dbpsw | output | 32 | Saved program status word |

## Verification
The redirect request and its target are combinational, so they are due in the cycle of the stimulus itself. The bench samples them one time step after driving the inputs on the falling edge. The saved PC, saved status word and updated status word are due one register later. The bench compares them with its behavioural model on the next falling edge, half a period after the capturing rising edge. The model is updated only on rising edges, from the inputs the bench drove.

// File: rtl/ito_pkg.sv
package ito_pkg;
    localparam int XLEN = 32;
    localparam logic [XLEN-1:0] HANDLER_VEC = 32'h0000_0060;

    // field positions of the reserved encoding
    localparam int OP_LO  = 5;
    localparam int OP_W   = 6;
    localparam int SUB_LO = 23;
    localparam int SUB_W  = 4;
    localparam int SEL_BIT = 16;
    localparam logic [SUB_W-1:0] SUB_MIN = 4'h7;

    localparam int FLAG_W = 8;

    typedef struct packed {
        logic [XLEN-FLAG_W-1:0] rsvd;
        logic np;
        logic ep;
        logic id;
        logic sat;
        logic cy;
        logic ov;
        logic s;
        logic z;
    } psw_t;

    localparam psw_t PSW_RESET = '{rsvd: '0, id: 1'b1, default: 1'b0};

    function automatic psw_t psw_clean(input logic [XLEN-1:0] raw);
        psw_t p;
        p = psw_t'(raw);
        p.rsvd = '0;
        return p;
    endfunction

    function automatic psw_t psw_enter_trap(input psw_t cur);
        psw_t p;
        p = cur;
        p.np = 1'b1;
        p.ep = 1'b1;
        p.id = 1'b1;
        return p;
    endfunction
endpackage

// File: rtl/ito_decode.sv
module ito_decode
    import ito_pkg::*;
(
    input  logic            exec_valid,
    input  logic [XLEN-1:0] instr,
    output logic            hit
);
    logic [OP_W-1:0]  op_f;
    logic [SUB_W-1:0] sub_f;
    logic             op_ok, sub_ok, sel_ok;

    always_comb begin
        op_f   = instr[OP_LO +: OP_W];
        sub_f  = instr[SUB_LO +: SUB_W];
        op_ok  = &op_f;
        sub_ok = (sub_f >= SUB_MIN);
        sel_ok = ~instr[SEL_BIT];
        hit    = exec_valid & op_ok & sub_ok & sel_ok;
    end

    always_comb begin
        AST_HIT_NEEDS_EXEC: assert (!hit || exec_valid); // R2
    end
endmodule

// File: rtl/ito_backup.sv
module ito_backup
    import ito_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            trap,
    input  logic [XLEN-1:0] ret_pc,
    input  psw_t            cur_psw,
    output logic [XLEN-1:0] dbpc,
    output psw_t            dbpsw
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dbpc  <= '0;
            dbpsw <= '0;
        end else if (trap) begin
            dbpc  <= ret_pc;
            dbpsw <= cur_psw;
        end
    end

    AST_DBPC_SAVE: assert property (@(posedge clk) disable iff (rst)
        trap |=> dbpc == $past(ret_pc)); // R4
    AST_DBPSW_SAVE: assert property (@(posedge clk) disable iff (rst)
        trap |=> dbpsw == $past(cur_psw)); // R5
    AST_BACKUP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !trap |=> $stable(dbpc) && $stable(dbpsw)); // R8
endmodule

// File: rtl/ito_psw_reg.sv
module ito_psw_reg
    import ito_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            trap,
    input  logic            wr,
    input  logic [XLEN-1:0] wdata,
    output psw_t            q
);
    psw_t nxt;

    always_comb begin
        nxt = q;
        if (trap)
            nxt = psw_enter_trap(q);
        else if (wr)
            nxt = psw_clean(wdata);
    end

    always_ff @(posedge clk) begin
        if (rst) q <= PSW_RESET;
        else     q <= nxt;
    end

    AST_TRAP_FLAGS: assert property (@(posedge clk) disable iff (rst)
        trap |=> q.np && q.ep && q.id); // R6
    AST_TRAP_KEEP_LOW: assert property (@(posedge clk) disable iff (rst)
        trap |=> q[4:0] == $past(q[4:0])); // R6
    AST_PSW_HOLD: assert property (@(posedge clk) disable iff (rst)
        !trap && !wr |=> $stable(q)); // R8
    AST_PSW_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        q.rsvd == '0); // R9
endmodule

// File: rtl/ito_trap_unit.sv
module ito_trap_unit
    import ito_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            exec_valid,
    input  logic [31:0]     instr,
    input  logic [31:0]     ret_pc,
    input  logic            psw_wr,
    input  logic [31:0]     psw_wdata,
    output logic            redir_valid,
    output logic [31:0]     redir_pc,
    output logic [31:0]     psw,
    output logic [31:0]     dbpc,
    output logic [31:0]     dbpsw
);
    logic trap;
    psw_t psw_q;
    psw_t dbpsw_q;

    ito_decode u_dec (
        .exec_valid (exec_valid),
        .instr      (instr),
        .hit        (trap)
    );

    ito_psw_reg u_psw (
        .clk   (clk),
        .rst   (rst),
        .trap  (trap),
        .wr    (psw_wr),
        .wdata (psw_wdata),
        .q     (psw_q)
    );

    ito_backup u_bak (
        .clk     (clk),
        .rst     (rst),
        .trap    (trap),
        .ret_pc  (ret_pc),
        .cur_psw (psw_q),
        .dbpc    (dbpc),
        .dbpsw   (dbpsw_q)
    );

    assign redir_valid = trap;
    assign redir_pc    = trap ? HANDLER_VEC : '0;
    assign psw         = psw_q;
    assign dbpsw       = dbpsw_q;

    AST_EP_AFTER_REDIR: assert property (@(posedge clk) disable iff (rst)
        redir_valid |=> psw[6]); // R6
    AST_REDIR_EXEC: assert property (@(posedge clk) disable iff (rst)
        redir_valid |-> exec_valid); // R2
endmodule

// File: tb/test_ito_trap_unit.sv
`timescale 1ns/100ps
module test_ito_trap_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        exec_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] ret_pc = '0;
    logic        psw_wr = 1'b0;
    logic [31:0] psw_wdata = '0;
    logic        redir_valid;
    logic [31:0] redir_pc, psw, dbpc, dbpsw;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ito_trap_unit i_ito_trap_unit (
        .clk(clk), .rst(rst), .exec_valid(exec_valid), .instr(instr),
        .ret_pc(ret_pc), .psw_wr(psw_wr), .psw_wdata(psw_wdata),
        .redir_valid(redir_valid), .redir_pc(redir_pc), .psw(psw),
        .dbpc(dbpc), .dbpsw(dbpsw)
    );

    // behavioural reference
    logic [31:0] m_psw, m_dbpc, m_dbpsw;
    string m_psw_tag = "R7";
    string m_bak_tag = "R7";

    function automatic bit ref_illegal(input logic [31:0] w);
        int sub;
        sub = w[26:23];
        return (w[10:5] == 6'b111111) && (sub >= 7) && (w[16] == 1'b0);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_psw <= 32'h20; m_dbpc <= 0; m_dbpsw <= 0;
            m_psw_tag <= "R7"; m_bak_tag <= "R7";
        end else if (exec_valid && ref_illegal(instr)) begin
            m_dbpc <= ret_pc;
            m_dbpsw <= m_psw;
            m_psw <= m_psw | 32'hE0;
            m_psw_tag <= psw_wr ? "R10" : "R6";
            m_bak_tag <= "R4";
        end else begin
            if (psw_wr) begin
                m_psw <= psw_wdata & 32'hFF;
                m_psw_tag <= "R9";
            end else m_psw_tag <= "R8";
            m_bak_tag <= "R8";
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // registered results compared half a period after each rising edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(m_psw_tag, psw, m_psw);
            check(m_bak_tag, dbpc, m_dbpc);
            check(m_bak_tag == "R4" ? "R5" : m_bak_tag, dbpsw, m_dbpsw);
        end
    end

    task automatic step(input logic ev, input logic [31:0] w, input logic [31:0] pc,
                        input logic wr, input logic [31:0] wd, input string tag);
        bit exp;
        @(negedge clk);
        exec_valid = ev; instr = w; ret_pc = pc; psw_wr = wr; psw_wdata = wd;
        #1;
        exp = ev && ref_illegal(w);
        check(tag, {31'b0, redir_valid}, {31'b0, exp});
        if (exp) check("R3", redir_pc, 32'h60);
    endtask

    function automatic logic [31:0] mk(input logic [3:0] sub, input logic b16,
                                       input logic [5:0] op, input logic [31:0] rest);
        logic [31:0] w;
        w = rest;
        w[26:23] = sub; w[16] = b16; w[10:5] = op;
        return w;
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R7 reset values, visible before any edge after release
        check("R7", psw, 32'h20);
        check("R7", dbpc, 32'h0);
        check("R7", dbpsw, 32'h0);
        // R9 write with upper junk
        step(0, 0, 0, 1, 32'hFFFF_FF1F, "R2");
        // R2 illegal word without execute strobe
        step(0, mk(4'hF, 0, 6'h3F, 32'h1234_5678), 32'h1000, 0, 0, "R2");
        // R1 basic trap
        step(1, mk(4'h7, 0, 6'h3F, 32'h0), 32'h0000_4004, 0, 0, "R1");
        // R11 boundaries
        step(1, mk(4'h6, 0, 6'h3F, 32'hFFFF_FFFF), 32'h2222, 0, 0, "R11");
        step(1, mk(4'hF, 1, 6'h3F, 32'h0), 32'h3333, 0, 0, "R11");
        for (int b = 0; b < 6; b++)
            step(1, mk(4'h9, 0, 6'h3F & ~(6'd1 << b), 32'hAAAA_AAAA), 32'h4444 + b, 0, 0, "R11");
        step(1, mk(4'hF, 0, 6'h3F, 32'hFFFF_FFFF & ~32'h0001_0000), 32'h5550, 0, 0, "R11");
        // R9 then R8 idle
        step(0, 0, 0, 1, 32'h0000_0013, "R2");
        step(1, 32'h0, 32'h6000, 0, 0, "R1");
        // R10 trap with simultaneous write
        step(1, mk(4'hC, 0, 6'h3F, 32'h0), 32'h7770, 1, 32'h0000_0001, "R10");
        // randomized mix
        for (int i = 0; i < 300; i++) begin
            logic [31:0] w;
            w = $urandom;
            if ($urandom_range(0, 1)) begin w[10:5] = 6'h3F; w[16] = 1'b0; end
            step($urandom_range(0, 3) != 0, w, $urandom, $urandom_range(0, 2) == 0,
                 $urandom, "R1");
        end
        step(0, 0, 0, 0, 0, "R2");
        @(negedge clk); #1;
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule